// File: doc/BRIEF.md
# Inbound and Outbound Packet Address Remapper

This block relocates addresses between a serial link and the local bus. Every inbound packet address arrives on a valid/ready stream. It is matched against four receive windows that are laid end to end: window n starts where the sizes of windows 1 to n-1 add up, and it covers its own size from there. A matched address is rebased into its window and then moved by that window's local offset. An address past the end of the last window is returned with a miss flag and no translated address.

The outbound direction is a purely combinational path. It takes a 26-bit slave bus address, subtracts a programmable transmit base from it, and produces an address that starts at zero. All nine configuration registers are loaded through a plain write strobe with a select and a data word.

The output stage is one register deep. A result appears one cycle after the input is accepted. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new input is taken.

Top module: `pkt_addr_remap`

## Requirements
- R1: On a clock edge with `cfg_we` high, `cfg_sel` picks the register that is loaded from `cfg_wdata`. Select 0 loads the transmit base. Selects 1 to 4 load the sizes of windows 1 to 4. Selects 5 to 8 load the offsets of windows 1 to 4.
- R2: After reset, `out_valid` is 0 and `in_ready` is 1. All sizes, all offsets and the transmit base are 0, so every inbound address misses and `tx_pkt_addr` equals `tx_slave_addr`.
- R3: An address below the size of window 1 translates to address + offset 1 (modulo 2^32), and `out_region` is 0.
- R4: Let S(n) be the sum of the sizes of windows 1 to n, computed without overflow. An address with S(n-1) <= a < S(n) translates to a - S(n-1) + offset n (modulo 2^32), and `out_region` is n-1.
- R5: A window of size 0 matches no address. Matching goes on to the next window, starting from the same running sum.
- R6: An address at or above S(4) gives `out_miss` = 1 and `out_addr` = 0.
- R7: A transfer is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is on the outputs, with `out_valid` high, right after that same edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. In that state, `out_addr`, `out_miss` and `out_region` hold their values.
- R9: `tx_pkt_addr[25:0]` = (`tx_slave_addr` - base) modulo 2^26, and `tx_pkt_addr[31:26]` = 0.
- R10: The transmit base keeps only bits [25:0] of the written word. Bits [31:26] of that write have no effect on `tx_pkt_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Register select (0 base, 1-4 sizes, 5-8 offsets) |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Inbound packet address valid |
| in_ready | output | 1 | Inbound address can be taken |
| in_addr | input | 32 | Inbound packet address |
| out_valid | output | 1 | Translation result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Local bus address (0 on a miss) |
| out_miss | output | 1 | Address is beyond all windows |
| out_region | output | 2 | Index of the window that matched |
| tx_slave_addr | input | 26 | Outbound slave bus address |
| tx_pkt_addr | output | 32 | Zero-relative outbound packet address |

## Verification
An inbound result is due on the first clock edge that accepts its input. The bench drives every input at a falling edge and reads the result at the next falling edge. In the idle-start case it also checks, just before that edge, that `out_valid` is still low. Configuration writes take effect at the edge that captures them, and no translation is issued in the same cycle as a write. The transmit result has no register on its path, so it is read one time step after its input changes. For back-pressure, the held output is read at several falling edges while the consumer stalls. The queued input is then expected one edge after `out_ready` rises.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned SEL_W      = 4;
  localparam int unsigned NUM_WIN    = 4;
  localparam logic [SEL_W-1:0] SEL_TXBASE = 4'd0;
  localparam logic [SEL_W-1:0] SEL_SIZE0  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_OFS0   = 4'd5;
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TX_W   = 26,
  parameter int unsigned NWIN   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [remap_pkg::SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0]            wdata,
  output logic [NWIN-1:0][ADDR_W-1:0]  size_q,
  output logic [NWIN-1:0][ADDR_W-1:0]  ofs_q,
  output logic [TX_W-1:0]              base_q
);
  import remap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (we && sel == SEL_TXBASE) base_q <= wdata[TX_W-1:0];
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [SEL_W-1:0] SZ_SEL = SEL_SIZE0 + SEL_W'(w);
    localparam logic [SEL_W-1:0] OF_SEL = SEL_OFS0 + SEL_W'(w);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q[w] <= '0;
        ofs_q[w]  <= '0;
      end else if (we) begin
        if (sel == SZ_SEL) size_q[w] <= wdata;
        if (sel == OF_SEL) ofs_q[w]  <= wdata;
      end
    end
  end
endmodule

// File: rtl/remap_match.sv
module remap_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NWIN   = 4,
  localparam int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned SUM_W = ADDR_W + IDX_W + 1
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NWIN-1:0][ADDR_W-1:0]  size_q,
  input  logic [NWIN-1:0][ADDR_W-1:0]  ofs_q,
  output logic                         miss,
  output logic [IDX_W-1:0]             idx,
  output logic [ADDR_W-1:0]            xaddr
);
  logic [NWIN:0][SUM_W-1:0]     bound;
  logic [NWIN-1:0]              hit;
  logic [NWIN-1:0][ADDR_W-1:0]  cand;
  logic [SUM_W-1:0]             addr_x;

  assign addr_x   = SUM_W'(addr);
  assign bound[0] = '0;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign bound[w+1] = bound[w] + SUM_W'(size_q[w]);
    assign hit[w]     = (addr_x >= bound[w]) && (addr_x < bound[w+1]);
    assign cand[w]    = addr - bound[w][ADDR_W-1:0] + ofs_q[w];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    idx   = '0;
    xaddr = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (!found && hit[w]) begin
        found = 1'b1;
        idx   = IDX_W'(w);
        xaddr = cand[w];
      end
    end
    miss = !found;
  end
endmodule

// File: rtl/remap_stage.sv
module remap_stage #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              d_miss,
  input  logic [IDX_W-1:0]  d_idx,
  input  logic [ADDR_W-1:0] d_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_miss,
  output logic [IDX_W-1:0]  out_idx,
  output logic [ADDR_W-1:0] out_addr
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_idx   <= '0;
      out_addr  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_miss  <= d_miss;
        out_idx   <= d_miss ? '0 : d_idx;
        out_addr  <= d_miss ? '0 : d_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/remap_tx.sv
module remap_tx #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TX_W   = 26
) (
  input  logic [TX_W-1:0]   slave_addr,
  input  logic [TX_W-1:0]   base,
  output logic [ADDR_W-1:0] pkt_addr
);
  logic [TX_W-1:0] rel;
  assign rel      = slave_addr - base;
  assign pkt_addr = ADDR_W'(rel);
endmodule

// File: rtl/pkt_addr_remap.sv
module pkt_addr_remap #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TX_W   = 26,
  parameter int unsigned NWIN   = remap_pkg::NUM_WIN,
  localparam int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [remap_pkg::SEL_W-1:0] cfg_sel,
  input  logic [ADDR_W-1:0]           cfg_wdata,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [ADDR_W-1:0]           in_addr,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [ADDR_W-1:0]           out_addr,
  output logic                        out_miss,
  output logic [IDX_W-1:0]            out_region,
  input  logic [TX_W-1:0]             tx_slave_addr,
  output logic [ADDR_W-1:0]           tx_pkt_addr
);
  logic [NWIN-1:0][ADDR_W-1:0] size_q;
  logic [NWIN-1:0][ADDR_W-1:0] ofs_q;
  logic [TX_W-1:0]             base_q;
  logic                        m_miss;
  logic [IDX_W-1:0]            m_idx;
  logic [ADDR_W-1:0]           m_addr;

  remap_cfg #(.ADDR_W(ADDR_W), .TX_W(TX_W), .NWIN(NWIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .size_q(size_q), .ofs_q(ofs_q), .base_q(base_q)
  );

  remap_match #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_match (
    .addr(in_addr), .size_q(size_q), .ofs_q(ofs_q),
    .miss(m_miss), .idx(m_idx), .xaddr(m_addr)
  );

  remap_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_miss(m_miss), .d_idx(m_idx), .d_addr(m_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_miss(out_miss),
    .out_idx(out_region), .out_addr(out_addr)
  );

  remap_tx #(.ADDR_W(ADDR_W), .TX_W(TX_W)) u_tx (
    .slave_addr(tx_slave_addr), .base(base_q), .pkt_addr(tx_pkt_addr)
  );
endmodule

// File: rtl/remap_checks.sv
module remap_checks #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_miss,
  input logic [IDX_W-1:0]  out_region,
  input logic [ADDR_W-1:0] tx_pkt_addr
);
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_miss) && $stable(out_region)));

  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_addr == '0 && out_region == '0));

  p_tx_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pkt_addr[ADDR_W-1:26] == '0);

  p_reset_idle_r2: assert property (@(posedge clk)
    !rst_n |=> (!out_valid || rst_n));
endmodule

bind pkt_addr_remap remap_checks #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
  .out_miss(out_miss), .out_region(out_region), .tx_pkt_addr(tx_pkt_addr)
);

// File: tb/pkt_addr_remap_test.sv
module pkt_addr_remap_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_miss;
  logic [1:0]  out_region;
  logic [25:0] tx_slave_addr = '0;
  logic [31:0] tx_pkt_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  longint sz [4];
  longint of [4];
  longint base;

  always #10 clk = ~clk;

  pkt_addr_remap uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_miss(out_miss), .out_region(out_region),
    .tx_slave_addr(tx_slave_addr), .tx_pkt_addr(tx_pkt_addr)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  // R1: select 0 base, 1..4 sizes, 5..8 offsets
  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s == 0) base = longint'(d[25:0]);
    else if (s <= 4) sz[s-1] = longint'(d);
    else if (s <= 8) of[s-5] = longint'(d);
  endtask

  task automatic set_map(input longint s0, s1, s2, s3, o0, o1, o2, o3);
    wr(4'd1, s0[31:0]); wr(4'd2, s1[31:0]); wr(4'd3, s2[31:0]); wr(4'd4, s3[31:0]);
    wr(4'd5, o0[31:0]); wr(4'd6, o1[31:0]); wr(4'd7, o2[31:0]); wr(4'd8, o3[31:0]);
  endtask

  // Sends one address (called at a falling edge) and checks the result one edge later.
  task automatic xl(input longint a, input string req);
    longint lo;
    longint ea;
    int     er;
    bit     em;
    lo = 0; em = 1; ea = 0; er = 0;
    for (int w = 0; w < 4; w++) begin
      if (em && a >= lo && a < lo + sz[w]) begin
        em = 0; er = w; ea = (a - lo + of[w]) & 64'hFFFF_FFFF;
      end
      lo = lo + sz[w];
    end
    in_valid = 1'b1; in_addr = a[31:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, longint'(out_valid), 1);
    chk({req, " miss"}, longint'(out_miss), longint'(em));
    chk({req, " addr"}, longint'(out_addr), ea);
    chk({req, " region"}, longint'(out_region), longint'(er));
  endtask

  task automatic txc(input longint sa, input string req);
    tx_slave_addr = sa[25:0];
    #1;
    chk(req, longint'(tx_pkt_addr), (sa - base) & 64'h3FF_FFFF);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 4; w++) begin sz[w] = 0; of[w] = 0; end
    base = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    chk("R2 out_valid", longint'(out_valid), 0);
    chk("R2 in_ready", longint'(in_ready), 1);
    txc(26'h123_4567, "R2 tx passthrough");
    xl(32'h0000_0000, "R2 miss after reset");

    // R3 R4 R5 R6: window 2 disabled, sweep past the end
    set_map(16, 0, 8, 32, 32'h1000_0000, 32'h2000_0000, 32'hFFFF_FFFC, 32'h0000_0100);
    for (int a = 0; a < 64; a++) xl(a, a < 16 ? "R3 sweep A" : (a < 56 ? "R4 R5 sweep A" : "R6 sweep A"));

    // R5: window 1 disabled
    set_map(0, 12, 0, 20, 32'h5, 32'h4000_0000, 32'h7, 32'h8000_0000);
    for (int a = 0; a < 40; a++) xl(a, a < 32 ? "R4 R5 sweep B" : "R6 sweep B");

    // R4: running sum past 2^32
    set_map(64'h8000_0000, 64'h8000_0000, 64'h8000_0000, 64'h8000_0000, 0, 32'h10, 32'h20, 32'h30);
    xl(32'h7FFF_FFFF, "R3 large");
    xl(32'h8000_0000, "R4 large lower edge");
    xl(32'hFFFF_FFFF, "R4 large top");

    // R6: all sizes zero -> everything misses
    set_map(0, 0, 0, 0, 1, 2, 3, 4);
    xl(32'h0, "R6 empty map low");
    xl(32'hFFFF_FFFF, "R6 empty map high");

    // R7: result due at the accepting edge, not before
    set_map(4, 4, 4, 4, 32'h100, 32'h200, 32'h300, 32'h400);
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'd5;
    #5 chk("R7 not yet valid", longint'(out_valid), 0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid after edge", longint'(out_valid), 1);
    chk("R7 addr", longint'(out_addr), 32'h201);
    @(negedge clk);
    chk("R7 drained", longint'(out_valid), 0);

    // R8: back-pressure
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 32'd9;
    @(negedge clk);
    chk("R8 first valid", longint'(out_valid), 1);
    chk("R8 first addr", longint'(out_addr), 32'h301);
    in_addr = 32'd14;
    #1 chk("R8 in_ready low", longint'(in_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 held addr", longint'(out_addr), 32'h301);
      chk("R8 held region", longint'(out_region), 2);
      chk("R8 held valid", longint'(out_valid), 1);
    end
    out_ready = 1'b1;
    #1 chk("R8 in_ready back", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 next addr", longint'(out_addr), 32'h402);
    chk("R8 next region", longint'(out_region), 3);
    @(negedge clk);
    chk("R8 empty", longint'(out_valid), 0);

    // R9: transmit subtraction with wrap
    foreach (sz[i]) begin end
    wr(4'd0, 32'h0000_1000);
    txc(26'h000_1000, "R9 equal");
    txc(26'h000_1234, "R9 above");
    txc(26'h000_0FFF, "R9 wrap");
    wr(4'd0, 32'h03FF_FFFF);
    txc(26'h0, "R9 max base");
    txc(26'h3FF_FFFF, "R9 max both");

    // R10: upper base bits are not kept
    wr(4'd0, 32'hFC00_0010);
    txc(26'h10, "R10 reserved ignored");
    txc(26'h5, "R10 reserved ignored wrap");
    wr(4'd0, 32'hFFFF_FFFF);
    txc(26'h3FF_FFFF, "R10 all ones");

    finish_run();
  end
endmodule